// File: doc/BRIEF.md
# Core-Side Internal Data RAM with Register Banks and Bit Addressing

This block is the 256-byte scratch memory that sits next to an 8051-compatible execution core. The core reaches it through three independent ports. A byte port carries an address, a write strobe and a flag that says whether the instruction used direct or indirect addressing. A register port takes a two-bit bank number and a three-bit register index and finds the matching byte in the low 32 bytes. A bit port reads, sets or clears one bit of the 16-byte bit-addressable window.

The upper half of the address space is shared with the special function registers. Those registers are kept in storage elsewhere. An indirect byte access above 0x7F reaches RAM. A direct byte access above 0x7F leaves RAM alone and raises a routing strobe so the external register file can answer. Bit addresses at 0x80 and above are sent to that same external file through a second strobe.

Reads are synchronous and each read port returns its data one cycle after the request. A port with no read in progress keeps its last value.

Top module: `idata_ram`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `byte_rdata`, `reg_rdata` and `bit_rdata` are 0. With no request, `sfr_sel` and `sfr_bit_sel` are 0.
- R2: An indirect byte access (`byte_indirect`=1) reaches RAM at any address from 0x00 to 0xFF. Write data given in one cycle is returned by a read of the same address, one cycle after the read request.
- R3: A direct byte access (`byte_indirect`=0) to an address from 0x00 to 0x7F behaves exactly like an indirect access to the same address.
- R4: A direct byte access with `byte_addr[7]`=1 drives `sfr_sel` high in the same cycle, combinationally. In that cycle RAM is not written and `byte_rdata` keeps its previous value.
- R5: A register-port access with bank `k` and index `i` reaches RAM byte `{3'b000, k, i}`, the same byte the byte port sees at that address.
- R6: A bit address `b` below 0x80 selects bit `b[2:0]` of byte `0x20 + b[6:3]`. A bit read returns that bit on `bit_rdata` one cycle later.
- R7: A bit write sets or clears only the selected bit, in a single cycle. The other seven bits of the byte are unchanged.
- R8: A bit access with `bit_addr[7]`=1 drives `sfr_bit_sel` high in the same cycle. It changes no RAM bit, and `bit_rdata` keeps its previous value.
- R9: When two ports write the same byte in the same cycle, the byte port beats both the register port and the bit port.
- R10: A request that writes also returns the data that was stored before the write (read-first) on its read output.
- R11: A read output keeps its value during cycles in which its port has no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_req | input | 1 | Byte port request |
| byte_we | input | 1 | Byte port write enable |
| byte_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| byte_addr | input | 8 | Byte address |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data, one cycle latency |
| sfr_sel | output | 1 | Direct access above 0x7F, routed to the external SFR file |
| reg_req | input | 1 | Register port request |
| reg_we | input | 1 | Register port write enable |
| reg_bank | input | 2 | Selected register bank |
| reg_idx | input | 3 | Register index 0 to 7 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle latency |
| bit_req | input | 1 | Bit port request |
| bit_we | input | 1 | Bit port write enable |
| bit_addr | input | 8 | Bit address |
| bit_wval | input | 1 | Value written to the bit |
| bit_rdata | output | 1 | Bit read data, one cycle latency |
| sfr_bit_sel | output | 1 | Bit address above 0x7F, routed to the external SFR file |

## Verification
The bench writes the top bytes 0x80 and 0xFF indirectly, then tries to overwrite 0x90 with a direct write. A decoder that ignores the mode flag would corrupt that upper RAM byte, and the bench would read the wrong value back through an indirect read. It also checks that a direct read leaves `byte_rdata` at its old value, and it sends bit addresses above 0x7F to find a design that drops address bit 7 and hits byte 0x20. Bit writes into bytes that already hold a pattern show whether the update clobbers the other bits. Same-cycle byte/bit and byte/register writes to one byte, and write-then-rewrite sequences, catch a wrong priority and a write-through read path.

// File: rtl/idata_pkg.sv
package idata_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BANK_W    = 2;
    localparam int RIDX_W    = 3;
    localparam int BPOS_W    = $clog2(DATA_W);
    localparam int BYTE_SEL_W = ADDR_W - 1 - BPOS_W;
    localparam int NUM_BYTE_PORTS = 2;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BPOS_W-1:0] bpos_t;

    localparam addr_t BIT_AREA_BASE = addr_t'(8'h20);

    typedef enum logic {
        MODE_DIRECT   = 1'b0,
        MODE_INDIRECT = 1'b1
    } amode_e;

    // whole-byte request toward the storage array
    typedef struct packed {
        logic  en;
        logic  we;
        addr_t addr;
        byte_t wdata;
    } byte_acc_t;

    // single-bit request toward the storage array
    typedef struct packed {
        logic  en;
        logic  we;
        addr_t addr;
        bpos_t pos;
        logic  val;
    } bit_acc_t;

    function automatic logic in_upper_half(input addr_t a);
        return a[ADDR_W-1];
    endfunction

    function automatic addr_t bank_reg_addr(input logic [BANK_W-1:0] bank,
                                            input logic [RIDX_W-1:0] idx);
        return addr_t'({bank, idx});
    endfunction

    function automatic addr_t bit_host_byte(input addr_t baddr);
        return BIT_AREA_BASE + addr_t'(baddr[ADDR_W-2:BPOS_W]);
    endfunction

    function automatic bpos_t bit_offset(input addr_t baddr);
        return baddr[BPOS_W-1:0];
    endfunction

endpackage

// File: rtl/idata_byte_route.sv
module idata_byte_route
    import idata_pkg::*;
(
    input  logic      req,
    input  logic      we,
    input  amode_e    mode,
    input  addr_t     addr,
    input  byte_t     wdata,
    output byte_acc_t ram_acc,
    output logic      to_sfr
);
    logic upper_direct;

    always_comb begin
        upper_direct    = in_upper_half(addr) && (mode == MODE_DIRECT);
        to_sfr          = req && upper_direct;
        ram_acc.en      = req && !upper_direct;
        ram_acc.we      = we;
        ram_acc.addr    = addr;
        ram_acc.wdata   = wdata;
    end
endmodule

// File: rtl/idata_bank_map.sv
module idata_bank_map
    import idata_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    input  logic [RIDX_W-1:0] idx,
    input  byte_t             wdata,
    output byte_acc_t         ram_acc
);
    always_comb begin
        ram_acc.en    = req;
        ram_acc.we    = we;
        ram_acc.addr  = bank_reg_addr(bank, idx);
        ram_acc.wdata = wdata;
    end
endmodule

// File: rtl/idata_bit_map.sv
module idata_bit_map
    import idata_pkg::*;
(
    input  logic     req,
    input  logic     we,
    input  addr_t    baddr,
    input  logic     val,
    output bit_acc_t ram_acc,
    output logic     to_sfr
);
    always_comb begin
        to_sfr       = req && in_upper_half(baddr);
        ram_acc.en   = req && !in_upper_half(baddr);
        ram_acc.we   = we;
        ram_acc.addr = bit_host_byte(baddr);
        ram_acc.pos  = bit_offset(baddr);
        ram_acc.val  = val;
    end
endmodule

// File: rtl/idata_store.sv
module idata_store
    import idata_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    // index order is write priority: highest index wins
    input  byte_acc_t byte_acc [NUM_BYTE_PORTS],
    input  bit_acc_t  bit_acc,
    output byte_t     byte_q   [NUM_BYTE_PORTS],
    output logic      bit_q
);
    byte_t mem [DEPTH];

    // storage: bit update first, whole-byte writes after so they override
    always_ff @(posedge clk) begin
        if (bit_acc.en && bit_acc.we) begin
            mem[bit_acc.addr][bit_acc.pos] <= bit_acc.val;
        end
        for (int p = 0; p < NUM_BYTE_PORTS; p++) begin
            if (byte_acc[p].en && byte_acc[p].we) begin
                mem[byte_acc[p].addr] <= byte_acc[p].wdata;
            end
        end
    end

    // read-first registered outputs, held while idle
    for (genvar g = 0; g < NUM_BYTE_PORTS; g++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q[g] <= '0;
            end else if (byte_acc[g].en) begin
                byte_q[g] <= mem[byte_acc[g].addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else if (bit_acc.en) begin
            bit_q <= mem[bit_acc.addr][bit_acc.pos];
        end
    end
endmodule

// File: rtl/idata_ram.sv
module idata_ram
    import idata_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_req,
    input  logic        byte_we,
    input  logic        byte_indirect,
    input  logic [7:0]  byte_addr,
    input  logic [7:0]  byte_wdata,
    output logic [7:0]  byte_rdata,
    output logic        sfr_sel,
    input  logic        reg_req,
    input  logic        reg_we,
    input  logic [1:0]  reg_bank,
    input  logic [2:0]  reg_idx,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        bit_req,
    input  logic        bit_we,
    input  logic [7:0]  bit_addr,
    input  logic        bit_wval,
    output logic        bit_rdata,
    output logic        sfr_bit_sel
);
    localparam int P_REG  = 0;
    localparam int P_BYTE = NUM_BYTE_PORTS - 1;

    byte_acc_t acc    [NUM_BYTE_PORTS];
    byte_t     rd_q   [NUM_BYTE_PORTS];
    bit_acc_t  bacc;
    amode_e    mode;

    assign mode = byte_indirect ? MODE_INDIRECT : MODE_DIRECT;

    idata_byte_route u_route (
        .req     (byte_req),
        .we      (byte_we),
        .mode    (mode),
        .addr    (byte_addr),
        .wdata   (byte_wdata),
        .ram_acc (acc[P_BYTE]),
        .to_sfr  (sfr_sel)
    );

    idata_bank_map u_bank (
        .req     (reg_req),
        .we      (reg_we),
        .bank    (reg_bank),
        .idx     (reg_idx),
        .wdata   (reg_wdata),
        .ram_acc (acc[P_REG])
    );

    idata_bit_map u_bit (
        .req     (bit_req),
        .we      (bit_we),
        .baddr   (bit_addr),
        .val     (bit_wval),
        .ram_acc (bacc),
        .to_sfr  (sfr_bit_sel)
    );

    idata_store u_store (
        .clk      (clk),
        .rst      (rst),
        .byte_acc (acc),
        .bit_acc  (bacc),
        .byte_q   (rd_q),
        .bit_q    (bit_rdata)
    );

    assign byte_rdata = rd_q[P_BYTE];
    assign reg_rdata  = rd_q[P_REG];
endmodule

// File: rtl/idata_ram_chk.sv
module idata_ram_chk (
    input logic       clk,
    input logic       rst,
    input logic       byte_req,
    input logic       byte_indirect,
    input logic [7:0] byte_addr,
    input logic [7:0] byte_rdata,
    input logic       sfr_sel,
    input logic       reg_req,
    input logic [7:0] reg_rdata,
    input logic       bit_req,
    input logic [7:0] bit_addr,
    input logic       bit_rdata,
    input logic       sfr_bit_sel
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (byte_rdata == 8'h00 && reg_rdata == 8'h00 && !bit_rdata));

    assert_idle_no_route_R1: assert property (@(posedge clk) disable iff (rst)
        (!byte_req |-> !sfr_sel) and (!bit_req |-> !sfr_bit_sel));

    assert_low_direct_ram_R3: assert property (@(posedge clk) disable iff (rst)
        (byte_req && !byte_addr[7]) |-> !sfr_sel);

    assert_indirect_ram_R2: assert property (@(posedge clk) disable iff (rst)
        (byte_req && byte_indirect) |-> !sfr_sel);

    assert_sfr_holds_rdata_R4: assert property (@(posedge clk) disable iff (rst)
        sfr_sel |=> $stable(byte_rdata));

    assert_sfr_bit_route_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_req && bit_addr[7]) |-> sfr_bit_sel);

    assert_sfr_bit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        sfr_bit_sel |=> $stable(bit_rdata));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!byte_req |=> $stable(byte_rdata)) and (!reg_req |=> $stable(reg_rdata))
        and (!bit_req |=> $stable(bit_rdata)));
endmodule

bind idata_ram idata_ram_chk chk_i (.*);

// File: tb/idata_ram_tb_top.sv
module idata_ram_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_req = 0, byte_we = 0, byte_indirect = 0;
    logic [7:0] byte_addr = 0, byte_wdata = 0, byte_rdata;
    logic       sfr_sel;
    logic       reg_req = 0, reg_we = 0;
    logic [1:0] reg_bank = 0;
    logic [2:0] reg_idx = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       bit_req = 0, bit_we = 0, bit_wval = 0;
    logic [7:0] bit_addr = 0;
    logic       bit_rdata, sfr_bit_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    idata_ram dut_i (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // each op starts at a negedge and ends at the next negedge
    task automatic byte_op(input logic we, input logic ind, input logic [7:0] a,
                           input logic [7:0] d, output logic [7:0] q, output logic sfr);
        byte_req = 1; byte_we = we; byte_indirect = ind; byte_addr = a; byte_wdata = d;
        #1 sfr = sfr_sel;
        @(negedge clk);
        q = byte_rdata;
        byte_req = 0; byte_we = 0;
    endtask

    task automatic reg_op(input logic we, input logic [1:0] b, input logic [2:0] i,
                          input logic [7:0] d, output logic [7:0] q);
        reg_req = 1; reg_we = we; reg_bank = b; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        q = reg_rdata;
        reg_req = 0; reg_we = 0;
    endtask

    task automatic bit_op(input logic we, input logic [7:0] a, input logic v,
                          output logic q, output logic sfr);
        bit_req = 1; bit_we = we; bit_addr = a; bit_wval = v;
        #1 sfr = sfr_bit_sel;
        @(negedge clk);
        q = bit_rdata;
        bit_req = 0; bit_we = 0;
    endtask

    task automatic wr_i(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] q; logic s;
        byte_op(1, 1, a, d, q, s);
    endtask

    function automatic logic [7:0] rd_dummy(input logic [7:0] x);
        return x;
    endfunction

    task automatic rd_i(input logic [7:0] a, output logic [7:0] q);
        logic s;
        byte_op(0, 1, a, 8'h00, q, s);
    endtask

    task automatic t_reset();
        chk("R1", "byte_rdata after reset", byte_rdata, 0);
        chk("R1", "reg_rdata after reset", reg_rdata, 0);
        chk("R1", "bit_rdata after reset", bit_rdata, 0);
        chk("R1", "sfr_sel idle", sfr_sel, 0);
        chk("R1", "sfr_bit_sel idle", sfr_bit_sel, 0);
    endtask

    task automatic t_indirect();
        logic [7:0] q;
        wr_i(8'h05, 8'h3C); wr_i(8'h7F, 8'hA1); wr_i(8'h80, 8'h5E); wr_i(8'hFF, 8'hC3);
        rd_i(8'h05, q); chk("R2", "indirect 0x05", q, 8'h3C);
        rd_i(8'h7F, q); chk("R2", "indirect 0x7F", q, 8'hA1);
        rd_i(8'h80, q); chk("R2", "indirect 0x80", q, 8'h5E);
        rd_i(8'hFF, q); chk("R2", "indirect 0xFF", q, 8'hC3);
    endtask

    task automatic t_direct_low();
        logic [7:0] q; logic s;
        byte_op(1, 0, 8'h40, 8'h96, q, s);
        chk("R3", "sfr_sel direct 0x40", s, 0);
        rd_i(8'h40, q); chk("R3", "direct write seen indirectly", q, 8'h96);
        byte_op(0, 0, 8'h7F, 8'h00, q, s);
        chk("R3", "direct read 0x7F", q, 8'hA1);
        chk("R3", "sfr_sel direct 0x7F", s, 0);
    endtask

    task automatic t_direct_high();
        logic [7:0] q; logic s;
        wr_i(8'h90, 8'hA5);
        wr_i(8'h10, 8'h3E);
        rd_i(8'h10, q);
        byte_op(0, 0, 8'h90, 8'h00, q, s);
        chk("R4", "sfr_sel direct read 0x90", s, 1);
        chk("R4", "byte_rdata held on direct upper read", q, 8'h3E);
        byte_op(1, 0, 8'h90, 8'h00, q, s);
        chk("R4", "sfr_sel direct write 0x90", s, 1);
        rd_i(8'h90, q); chk("R4", "upper RAM untouched by direct write", q, 8'hA5);
    endtask

    task automatic t_banks();
        logic [7:0] q;
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 8; r++)
                reg_op(1, 2'(b), 3'(r), 8'(8'hC0 ^ (b * 8 + r) * 3), q);
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < 8; r++) begin
                rd_i(8'(b * 8 + r), q);
                chk("R5", $sformatf("bank %0d r%0d via byte port", b, r), q,
                    8'(8'hC0 ^ (b * 8 + r) * 3));
            end
        wr_i(8'h1B, 8'h77);
        reg_op(0, 2'd3, 3'd3, 8'h00, q);
        chk("R5", "byte write seen by bank 3 r3", q, 8'h77);
    endtask

    task automatic t_bits();
        logic [7:0] q; logic bq, s;
        wr_i(8'h2C, 8'hA0);
        bit_op(1, 8'h63, 1, bq, s);
        chk("R7", "sfr_bit_sel low bit addr", s, 0);
        rd_i(8'h2C, q); chk("R7", "set bit3 of 0x2C", q, 8'hA8);
        wr_i(8'h20, 8'hFF);
        bit_op(1, 8'h07, 0, bq, s);
        rd_i(8'h20, q); chk("R7", "clear bit7 of 0x20", q, 8'h7F);
        wr_i(8'h2F, 8'h80);
        bit_op(0, 8'h7F, 0, bq, s); chk("R6", "bit 0x7F reads 0x2F.7", bq, 1);
        bit_op(0, 8'h7E, 0, bq, s); chk("R6", "bit 0x7E reads 0x2F.6", bq, 0);
        bit_op(0, 8'h65, 0, bq, s); chk("R6", "bit 0x65 reads 0x2C.5", bq, 1);
    endtask

    task automatic t_bit_sfr();
        logic [7:0] q; logic bq, s;
        wr_i(8'h20, 8'h00);
        bit_op(0, 8'h7F, 0, bq, s);
        bit_op(1, 8'h85, 1, bq, s);
        chk("R8", "sfr_bit_sel on 0x85", s, 1);
        chk("R8", "bit_rdata held", bq, 1);
        rd_i(8'h20, q); chk("R8", "byte 0x20 untouched", q, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] q;
        byte_req = 1; byte_we = 1; byte_indirect = 1; byte_addr = 8'h24; byte_wdata = 8'h5A;
        bit_req = 1; bit_we = 1; bit_addr = 8'h20; bit_wval = 1;
        @(negedge clk);
        byte_req = 0; byte_we = 0; bit_req = 0; bit_we = 0;
        rd_i(8'h24, q); chk("R9", "byte beats bit", q, 8'h5A);
        byte_req = 1; byte_we = 1; byte_indirect = 0; byte_addr = 8'h09; byte_wdata = 8'h11;
        reg_req = 1; reg_we = 1; reg_bank = 2'd1; reg_idx = 3'd1; reg_wdata = 8'h22;
        @(negedge clk);
        byte_req = 0; byte_we = 0; reg_req = 0; reg_we = 0;
        rd_i(8'h09, q); chk("R9", "byte beats register", q, 8'h11);
    endtask

    task automatic t_read_first();
        logic [7:0] q; logic s, bq;
        wr_i(8'h31, 8'h10);
        byte_op(1, 1, 8'h31, 8'h20, q, s);
        chk("R10", "byte write returns old data", q, 8'h10);
        reg_op(1, 2'd2, 3'd6, 8'h4D, q);
        reg_op(1, 2'd2, 3'd6, 8'h00, q);
        chk("R10", "register write returns old data", q, 8'h4D);
        bit_op(1, 8'h79, 0, bq, s);
        bit_op(1, 8'h79, 1, bq, s);
        chk("R10", "bit write returns old bit", bq, 0);
    endtask

    task automatic t_hold();
        logic [7:0] q; logic bq, s;
        rd_i(8'hFF, q);
        reg_op(0, 2'd1, 3'd1, 8'h00, q);
        bit_op(0, 8'h79, 0, bq, s);
        repeat (3) @(negedge clk);
        chk("R11", "byte_rdata held idle", byte_rdata, 8'hC3);
        chk("R11", "reg_rdata held idle", reg_rdata, 8'h11);
        chk("R11", "bit_rdata held idle", bit_rdata, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_indirect();
        t_direct_low();
        t_direct_high();
        t_banks();
        t_bits();
        t_bit_sfr();
        t_collide();
        t_read_first();
        t_hold();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule